// File: doc/BRIEF.md
# Reciprocal Counter Gate Synchronizer

This block sits at the heart of a two-counter frequency meter. A host raises a coarse gate request. The block re-times that request twice. The first re-timing lines it up with the measured signal, which gives gate 1. The second lines gate 1 up with a fast reference, which gives gate 2. While gate 1 is open, an event counter counts measured-signal edges. While gate 2 is open, a time counter counts fast-reference edges. Because both gates are whole multiples of their own periods, the host can divide the two totals to get a frequency free of the usual plus-or-minus-one error on the event side.

All activity is presented to the block as single-cycle tick enables in the host clock domain: one for measured-signal edges, one for the fast reference and one for the slow reference. In conventional mode, gate 1 is re-timed to the slow reference instead, and gate 2 follows measured-signal edges. Each counter is a short prescaler followed by a wide extension, and the host reads it as a single total. A signal-present flag arms both re-timing stages. A gate-status flag shows gate 1, stretched so that short gates stay visible. A done flag marks the point where both totals are final.

Top module: `recip_gate_core`

## Requirements
- R1: A synchronous measurement clear forces both totals to zero and drives the signal-present, gate-status and done flags low in the cycle after it is sampled. An asynchronous active-low reset gives the same state.
- R2: The signal-present flag goes high in the cycle after the first measured-signal tick that follows a clear, and stays high until the next clear.
- R3: Until signal-present is high, neither gate can open. A gate request raised with no measured-signal activity leaves the totals at zero and the gate-status and done flags low.
- R4: In reciprocal mode (mode input 0), gate 1 opens at the first measured tick that samples the request high, and closes at the first later measured tick that samples it low. The event total equals the number of measured ticks after the opening tick, up to and including the closing tick.
- R5: Gate 2 samples gate 1 at each stage-2 tick. In reciprocal mode the stage-2 tick is the fast reference. The time total counts fast ticks while gate 2 is high, so with a fast tick every cycle it equals the width of gate 2 in cycles.
- R6: In conventional mode (mode input 1), gate 1 is re-timed on slow-reference ticks and gate 2 on measured-signal ticks. The event total still counts measured ticks while gate 1 is open.
- R7: Done is high exactly when gate 1 has closed and gate 2 is low. Done is never high before gate 1 closes. While done is high and no clear arrives, both totals hold.
- R8: After gate 1 has closed once, any further gate request is ignored until the next clear.
- R9: Gate status is high from the cycle gate 1 opens through 16 cycles after gate 1 falls, and is low after that.
- R10: Each total is the extension count times 2^P plus the prescaler count, with P = 7 for the event counter and P = 8 for the time counter. The prescaler carry advances the extension.
- R11: With saturation enabled, a total that reaches all ones holds there instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_clr | input | 1 | Synchronous measurement clear |
| mode_conv | input | 1 | 0 = reciprocal, 1 = conventional |
| gate_req | input | 1 | Coarse host gate request |
| sig_tick | input | 1 | One-cycle pulse per measured-signal edge |
| fast_tick | input | 1 | One-cycle pulse per fast-reference edge |
| slow_tick | input | 1 | One-cycle pulse per slow-reference edge |
| sig_present | output | 1 | Measured activity seen since the last clear |
| gate_stat | output | 1 | Stretched gate 1 status |
| done | output | 1 | Both totals are final |
| ev_total | output | EV_PRE_W+EXT_W | Event total (39 bits by default) |
| tm_total | output | TM_PRE_W+EXT_W | Time total (40 bits by default) |

## Verification
The closing edge of a gate can also be the edge that makes a prescaler carry into its extension. In that case the last increment, the extension step and the start of done all occur in the same cycle. The bench provokes this by ticking the measured signal every cycle for a 256-tick gate. Both the 7-bit and 8-bit prescalers then wrap exactly on their final counted edge. The scoreboard compares the totals seen at the rising edge of done against the values worked out from the tick schedule, and checks them again later to confirm they have stopped moving.

// File: rtl/recip_pkg.sv
package recip_pkg;

   typedef enum logic {
      MODE_RECIP = 1'b0,
      MODE_CONV  = 1'b1
   } meas_mode_e;

   function automatic int unsigned hold_width(input int unsigned hold);
      return (hold < 2) ? 1 : $clog2(hold + 1);
   endfunction

endpackage

// File: rtl/rc_gate_sync.sv
module rc_gate_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic arm,
   input  logic req,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= 1'b0;
      else if (clr)          q <= 1'b0;
      else if (tick && arm)  q <= req;
   end

   // R3: an unarmed stage never moves
   a_r3_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !clr) |=> $stable(q));

   // R4: the output only moves on a sampling tick
   a_r4_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(q));

endmodule

// File: rtl/rc_prescaled_count.sv
module rc_prescaled_count #(
   parameter int unsigned PRE_W    = 7,
   parameter int unsigned EXT_W    = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   inc,
   output logic [PRE_W+EXT_W-1:0] total
);

   localparam int unsigned TOT_W = PRE_W + EXT_W;

   initial begin
      assert (PRE_W >= 1 && PRE_W <= 16) else $error("PRE_W out of range");
      assert (EXT_W >= 1 && EXT_W <= 48) else $error("EXT_W out of range");
   end

   logic [PRE_W-1:0] pre_q;
   logic [EXT_W-1:0] ext_q;
   logic             carry;
   logic             full;
   logic             step;

   assign carry = &pre_q;
   assign full  = carry & (&ext_q);

   generate
      if (SATURATE) begin : g_sat
         assign step = inc & ~full;
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         ext_q <= '0;
      end else if (clr) begin
         pre_q <= '0;
         ext_q <= '0;
      end else if (step) begin
         pre_q <= pre_q + 1'b1;
         if (carry) ext_q <= ext_q + 1'b1;
      end
   end

   assign total = {ext_q, pre_q};

   // R10: the combined total advances by at most one per cycle
   a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (total == $past(total) || total == $past(total) + 1'b1));

   generate
      if (SATURATE) begin : g_sat_chk
         // R11: a full total stays full
         a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (&total && !clr) |=> &total);
      end
   endgenerate

   logic [TOT_W-1:0] unused_w;
   assign unused_w = total;

endmodule

// File: rtl/rc_gate_stretch.sv
module rc_gate_stretch
   import recip_pkg::*;
#(
   parameter int unsigned HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic gate,
   output logic stat
);

   localparam int unsigned CW = hold_width(HOLD);
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

   initial begin
      assert (HOLD >= 1 && HOLD <= 65535) else $error("HOLD out of range");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (gate)           cnt_q <= HOLD_C;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign stat = gate | (cnt_q != '0);

   // R9: status survives the falling edge of the gate
   a_r9_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate) && !$past(clr)) |-> stat);

endmodule

// File: rtl/recip_gate_core.sv
module recip_gate_core
   import recip_pkg::*;
#(
   parameter int unsigned EV_PRE_W  = 7,
   parameter int unsigned TM_PRE_W  = 8,
   parameter int unsigned EXT_W     = 32,
   parameter int unsigned STAT_HOLD = 16,
   parameter bit          SATURATE  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      meas_clr,
   input  logic                      mode_conv,
   input  logic                      gate_req,
   input  logic                      sig_tick,
   input  logic                      fast_tick,
   input  logic                      slow_tick,
   output logic                      sig_present,
   output logic                      gate_stat,
   output logic                      done,
   output logic [EV_PRE_W+EXT_W-1:0] ev_total,
   output logic [TM_PRE_W+EXT_W-1:0] tm_total
);

   localparam int unsigned EV_W = EV_PRE_W + EXT_W;
   localparam int unsigned TM_W = TM_PRE_W + EXT_W;

   initial begin
      assert (EV_W <= 64 && TM_W <= 64) else $error("total width too large");
   end

   meas_mode_e mode;
   logic       seen_q;
   logic       tick1, tick2;
   logic       g1, g2;
   logic       spent_q;
   logic       g1_closing;

   assign mode = meas_mode_e'(mode_conv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (meas_clr)  seen_q <= 1'b0;
      else if (sig_tick)  seen_q <= 1'b1;
   end

   assign tick1 = (mode == MODE_CONV) ? slow_tick : sig_tick;
   assign tick2 = (mode == MODE_CONV) ? sig_tick  : fast_tick;

   rc_gate_sync u_sync1 (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (meas_clr),
      .tick  (tick1),
      .arm   (seen_q),
      .req   (gate_req & ~spent_q),
      .q     (g1)
   );

   rc_gate_sync u_sync2 (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (meas_clr),
      .tick  (tick2),
      .arm   (seen_q),
      .req   (g1),
      .q     (g2)
   );

   assign g1_closing = g1 & tick1 & seen_q & ~gate_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          spent_q <= 1'b0;
      else if (meas_clr)   spent_q <= 1'b0;
      else if (g1_closing) spent_q <= 1'b1;
   end

   rc_prescaled_count #(
      .PRE_W    (EV_PRE_W),
      .EXT_W    (EXT_W),
      .SATURATE (SATURATE)
   ) u_ev_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (meas_clr),
      .inc   (sig_tick & g1),
      .total (ev_total)
   );

   rc_prescaled_count #(
      .PRE_W    (TM_PRE_W),
      .EXT_W    (EXT_W),
      .SATURATE (SATURATE)
   ) u_tm_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (meas_clr),
      .inc   (fast_tick & g2),
      .total (tm_total)
   );

   rc_gate_stretch #(
      .HOLD (STAT_HOLD)
   ) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (meas_clr),
      .gate  (g1),
      .stat  (gate_stat)
   );

   assign sig_present = seen_q;
   assign done        = spent_q & ~g2;

   // R1: a clear empties both totals and the flags
   a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      meas_clr |=> (ev_total == '0 && tm_total == '0 && !sig_present && !done));

   // R7: totals are frozen once done is high
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !meas_clr) |=> ($stable(ev_total) && $stable(tm_total)));

   // R8: gate 1 does not reopen in the same measurement
   a_r8_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      (spent_q && !meas_clr) |=> !g1);

   // R2: signal present never drops without a clear
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_present && !meas_clr) |=> sig_present);

endmodule

// File: tb/recip_gate_core_tb.sv
module recip_gate_core_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic meas_clr = 1'b0;
   logic mode_conv = 1'b0;
   logic gate_req = 1'b0;
   logic sig_tick = 1'b0;
   logic fast_tick = 1'b0;
   logic slow_tick = 1'b0;
   logic sig_present, gate_stat, done;
   logic [38:0] ev_total;
   logic [39:0] tm_total;
   logic s_present, s_stat, s_done;
   logic [7:0] s_ev;
   logic [8:0] s_tm;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   typedef struct {
      longint ev;
      longint tm;
      string  ev_tag;
      string  tm_tag;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   recip_gate_core u_dut (
      .clk(clk), .rst_n(rst_n), .meas_clr(meas_clr), .mode_conv(mode_conv),
      .gate_req(gate_req), .sig_tick(sig_tick), .fast_tick(fast_tick),
      .slow_tick(slow_tick), .sig_present(sig_present), .gate_stat(gate_stat),
      .done(done), .ev_total(ev_total), .tm_total(tm_total)
   );

   recip_gate_core #(.EXT_W(1)) u_sat (
      .clk(clk), .rst_n(rst_n), .meas_clr(meas_clr), .mode_conv(mode_conv),
      .gate_req(gate_req), .sig_tick(sig_tick), .fast_tick(fast_tick),
      .slow_tick(slow_tick), .sig_present(s_present), .gate_stat(s_stat),
      .done(s_done), .ev_total(s_ev), .tm_total(s_tm)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit tick_at(input int c, input int p);
      if (p <= 0) return 1'b0;
      return (c % p) == 0;
   endfunction

   function automatic bit req_at(input int c, input int on1, input int len1,
                                 input int on2, input int len2);
      return (c >= on1 && c < on1 + len1) || (c >= on2 && c < on2 + len2);
   endfunction

   // monitor: compare totals at each rising edge of done
   bit done_d = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done && !done_d) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(64'(ev_total) == e.ev, {e.ev_tag, " event total"}, 64'(ev_total), e.ev);
               chk(64'(tm_total) == e.tm, {e.tm_tag, " time total"}, 64'(tm_total), e.tm);
            end
         end
         done_d = done;
      end
   end

   task automatic clear_meas(input bit conv);
      @(negedge clk);
      mode_conv = conv; meas_clr = 1'b1;
      gate_req = 1'b0; sig_tick = 1'b0; fast_tick = 1'b0; slow_tick = 1'b0;
      @(negedge clk);
      meas_clr = 1'b0;
      chk(ev_total == '0 && tm_total == '0, "R1 totals after clear", 64'(ev_total), 0);
      chk(!sig_present && !gate_stat && !done, "R1 flags after clear",
          {sig_present, gate_stat, done}, 0);
   endtask

   // driver: compute expectations from the tick schedule, push, then drive
   task automatic run_meas(input bit conv, input int sp, input int sl,
                           input int on1, input int len1, input int on2, input int len2,
                           input int total, input string ev_tag, input string tm_tag);
      int a = -1;
      int b = -1;
      int r = -1;
      int f = -1;
      longint ev = 0;
      bit seen = 1'b0;
      int stat_bad = 0;
      int done_bad = 0;
      exp_t e;
      for (int c = 0; c < total; c++) begin
         bit sg, s1, rq;
         sg = tick_at(c, sp);
         s1 = conv ? tick_at(c, sl) : sg;
         rq = req_at(c, on1, len1, on2, len2);
         if (a < 0) begin
            if (s1 && rq && seen) a = c;
         end else if (b < 0) begin
            if (s1 && seen && !rq) b = c;
         end
         if (sg) seen = 1'b1;
      end
      for (int c = a + 1; c <= b; c++) if (tick_at(c, sp)) ev++;
      for (int c = a + 1; c < total; c++) begin
         bit s2;
         s2 = conv ? tick_at(c, sp) : 1'b1;
         if (s2 && r < 0) r = c;
         if (s2 && c > b && f < 0) f = c;
      end
      e.ev = ev; e.tm = longint'(f - r); e.ev_tag = ev_tag; e.tm_tag = tm_tag;
      exp_q.push_back(e);

      clear_meas(conv);
      for (int c = 0; c < total; c++) begin
         bit st_exp;
         sig_tick  = tick_at(c, sp);
         slow_tick = tick_at(c, sl);
         fast_tick = 1'b1;
         gate_req  = req_at(c, on1, len1, on2, len2);
         @(negedge clk);
         st_exp = (c >= a) && (c < b + 16);
         if (gate_stat !== st_exp) stat_bad++;
         if (c < b && done) done_bad++;
      end
      sig_tick = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0; gate_req = 1'b0;
      @(negedge clk);
      chk(stat_bad == 0, "R9 stretched gate status window", stat_bad, 0);
      chk(done_bad == 0, "R7 done before gate 1 closed", done_bad, 0);
      chk(done == 1'b1, "R7 done after gate 2 closed", done, 1);
      chk(64'(ev_total) == e.ev, "R8 event total unchanged at end", 64'(ev_total), e.ev);
      chk(64'(tm_total) == e.tm, "R8 time total unchanged at end", 64'(tm_total), e.tm);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ev_total == '0 && tm_total == '0, "R1 totals in reset", 64'(ev_total), 0);
      chk(!sig_present && !gate_stat && !done, "R1 flags in reset",
          {sig_present, gate_stat, done}, 0);
      rst_n = 1'b1;

      // R3 / R2: no measured activity, then a single tick
      clear_meas(1'b0);
      gate_req = 1'b1; fast_tick = 1'b1; slow_tick = 1'b1;
      repeat (40) @(negedge clk);
      chk(ev_total == '0 && tm_total == '0, "R3 totals without signal", 64'(tm_total), 0);
      chk(!gate_stat && !done, "R3 gate stays shut without signal", {gate_stat, done}, 0);
      chk(!sig_present, "R2 flag low without activity", sig_present, 0);
      gate_req = 1'b0; fast_tick = 1'b0; slow_tick = 1'b0; sig_tick = 1'b1;
      @(negedge clk);
      sig_tick = 1'b0;
      chk(sig_present, "R2 flag set by a measured tick", sig_present, 1);
      repeat (5) @(negedge clk);
      chk(sig_present && !gate_stat, "R2 flag holds, no gate", {sig_present, gate_stat}, 2);

      // R4 / R5: reciprocal mode
      run_meas(1'b0, 5, 0, 3, 40, 0, 0, 120, "R4", "R5");
      // R8: second request after the gate closed
      run_meas(1'b0, 7, 0, 10, 30, 70, 20, 150, "R4 R8", "R5 R8");
      // R6: conventional mode
      run_meas(1'b1, 3, 10, 5, 37, 0, 0, 160, "R6", "R6");
      // R10: last counted edge also carries both prescalers
      run_meas(1'b0, 1, 0, 2, 256, 0, 0, 300, "R10", "R10");
      chk(ev_total[6:0] == 7'd0 && ev_total[38:7] == 32'd2, "R10 event field split",
          64'(ev_total), 256);
      chk(tm_total[7:0] == 8'd0 && tm_total[39:8] == 32'd1, "R10 time field split",
          64'(tm_total), 256);
      // R11: narrow instance saturates
      run_meas(1'b0, 1, 0, 2, 600, 0, 0, 650, "R10", "R10");
      chk(s_ev == 8'hFF, "R11 event total saturates", s_ev, 255);
      chk(s_tm == 9'h1FF, "R11 time total saturates", s_tm, 511);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R7 every expected done observed", exp_q.size(), 0);
      finish_run();
   end

endmodule